// File: doc/BRIEF.md
# CPU condition code update unit

This block holds the 8-bit processor status register and rewrites its flag bits after every operation. Each cycle the surrounding datapath presents an operation-class code, the sign bits of the two operands, the result (16 bits wide, with the low byte used by 8-bit classes), and the carry and half-carry from the ALU. The class code decides which of the carry, overflow, zero, negative and half-carry flags are rewritten and from what. Every flag the class does not name keeps its value.

The two interrupt mask bits and the stop-disable bit change only through a direct-write class. That class loads the whole register from the low byte of the result bus. Software may clear the non-maskable interrupt mask through it, but may never set that mask again. Decoding, the ALU itself and interrupt sequencing stay outside the block.

Register layout, from MSB to LSB: bit 7 stop disable, bit 6 non-maskable interrupt mask, bit 5 half carry H, bit 4 interrupt mask, bit 3 negative N, bit 2 zero Z, bit 1 overflow V, bit 0 carry C. Class codes: 0 hold, 1 add, 2 subtract/compare, 3 move (load, store, logic), 4 shift/rotate, 5 multiply/divide, 6 index increment/decrement, 7 direct write. Codes 8 to 15 act as hold.

Top module: `ccr_unit`

## Requirements
- R1: While rst_n is low, and after it is released, the register reads 0xD0: stop disable, both interrupt masks set, all five flags cleared.
- R2: Add (code 1) sets C from alu_c and H from alu_h. V is set when both operand signs are equal and the result sign differs from them. N takes result bit 7. Z is set when the result low byte is zero.
- R3: Subtract/compare (code 2) sets C from alu_c (borrow). V is set when the operand signs differ and the result sign differs from the first operand. N and Z come from the low byte. H is held.
- R4: Move (code 3) sets N and Z from the low byte and clears V. C and H are held.
- R5: Shift/rotate (code 4) loads the bit shifted out, given on alu_c, into C. N and Z come from the low byte, V becomes N xor the new C, and H is held.
- R6: Multiply/divide (code 5) sets C from alu_c and sets Z when all 16 result bits are zero. N, V and H are held.
- R7: Index increment/decrement (code 6) changes only Z, which is set when all 16 result bits are zero. A result of 0x0100 therefore gives Z = 0.
- R8: Hold (code 0) and codes 8 to 15 leave the whole register unchanged.
- R9: Direct write (code 7) loads res[7:0] into the register. Bit 6 is loaded as res[6] AND its old value, so it can be cleared but never set.
- R10: Bits 7, 6 and 4 change only under direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_cls | input | 4 | Operation-class code |
| a_msb | input | 1 | Sign bit of the first operand |
| b_msb | input | 1 | Sign bit of the second operand |
| res | input | 16 | Operation result; low byte for 8-bit classes and write data |
| alu_c | input | 1 | ALU carry, borrow or shifted-out bit |
| alu_h | input | 1 | ALU carry out of bit 3 |
| ccr | output | 8 | Full status register |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_h | output | 1 | Half carry |
| irq_mask | output | 1 | Interrupt mask |
| xirq_mask | output | 1 | Non-maskable interrupt mask |
| stop_dis | output | 1 | Stop disable |

## Verification
The assertions assume that op_cls, the operand signs, res and the ALU bits are stable and defined at each rising edge while reset is released. They make no assumption that res, alu_c or alu_h are consistent with one another. The stimulus changes inputs only on falling edges. It drives arbitrary result and carry combinations, including ones no real ALU would produce, so that each flag is shown to follow its own input rather than a value derived from another flag.

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter logic [7:0] RST_VAL = 8'hD0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op_cls,
  input  logic        a_msb,
  input  logic        b_msb,
  input  logic [15:0] res,
  input  logic        alu_c,
  input  logic        alu_h,
  output logic [7:0]  ccr,
  output logic        flag_c,
  output logic        flag_v,
  output logic        flag_z,
  output logic        flag_n,
  output logic        flag_h,
  output logic        irq_mask,
  output logic        xirq_mask,
  output logic        stop_dis
);
  localparam logic [3:0] CLS_ADD = 4'd1, CLS_SUB = 4'd2, CLS_MOVE = 4'd3,
                         CLS_SHIFT = 4'd4, CLS_MULDIV = 4'd5, CLS_IDX = 4'd6,
                         CLS_WRITE = 4'd7;
  localparam int BC = 0, BV = 1, BZ = 2, BN = 3, BI = 4, BH = 5, BX = 6, BS = 7;

  logic [7:0] nxt;
  logic z8, z16, r7, v_add, v_sub;

  assign r7    = res[7];
  assign z8    = (res[7:0] == 8'h00);
  assign z16   = (res == 16'h0000);
  assign v_add = (a_msb == b_msb) && (r7 != a_msb);
  assign v_sub = (a_msb != b_msb) && (r7 != a_msb);

  always_comb begin
    nxt = ccr;
    case (op_cls)
      CLS_ADD: begin
        nxt[BC] = alu_c; nxt[BH] = alu_h; nxt[BV] = v_add;
        nxt[BN] = r7;    nxt[BZ] = z8;
      end
      CLS_SUB: begin
        nxt[BC] = alu_c; nxt[BV] = v_sub; nxt[BN] = r7; nxt[BZ] = z8;
      end
      CLS_MOVE: begin
        nxt[BV] = 1'b0; nxt[BN] = r7; nxt[BZ] = z8;
      end
      CLS_SHIFT: begin
        nxt[BC] = alu_c; nxt[BN] = r7; nxt[BZ] = z8; nxt[BV] = r7 ^ alu_c;
      end
      CLS_MULDIV: begin
        nxt[BC] = alu_c; nxt[BZ] = z16;
      end
      CLS_IDX:   nxt[BZ] = z16;
      CLS_WRITE: nxt = {res[7], res[6] & ccr[BX], res[5:0]};
      default:   nxt = ccr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ccr <= RST_VAL;
    else        ccr <= nxt;
  end

  assign flag_c    = ccr[BC];
  assign flag_v    = ccr[BV];
  assign flag_z    = ccr[BZ];
  assign flag_n    = ccr[BN];
  assign flag_h    = ccr[BH];
  assign irq_mask  = ccr[BI];
  assign xirq_mask = ccr[BX];
  assign stop_dis  = ccr[BS];

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls != CLS_WRITE) |=> $stable({stop_dis, xirq_mask, irq_mask})); // R10
  AST_XIRQ_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    !xirq_mask |=> !xirq_mask); // R9
  AST_IDX_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_IDX) |=> ({ccr[7:3], ccr[1:0]} == $past({ccr[7:3], ccr[1:0]}))); // R7
  AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == 4'd0 || op_cls > CLS_WRITE) |=> $stable(ccr)); // R8
  AST_MOVE_VCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_MOVE) |=> (!flag_v && $stable(flag_c))); // R4
  AST_SUB_HHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_SUB) |=> $stable(flag_h)); // R3
  AST_ADD_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_ADD) |=> (flag_c == $past(alu_c) && flag_h == $past(alu_h))); // R2
  AST_MUL_NVH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_MULDIV) |=> $stable({flag_n, flag_v, flag_h})); // R6
  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls == CLS_SHIFT) |=> (flag_v == (flag_n ^ flag_c))); // R5
endmodule

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_cls = 4'd0;
  logic a_msb = 1'b0, b_msb = 1'b0, alu_c = 1'b0, alu_h = 1'b0;
  logic [15:0] res = 16'h0;
  logic [7:0] ccr;
  logic flag_c, flag_v, flag_z, flag_n, flag_h, irq_mask, xirq_mask, stop_dis;

  int n_vec = 0, n_bad = 0;
  logic [7:0] model = 8'hD0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_unit u0 (.clk, .rst_n, .op_cls, .a_msb, .b_msb, .res, .alu_c, .alu_h,
               .ccr, .flag_c, .flag_v, .flag_z, .flag_n, .flag_h,
               .irq_mask, .xirq_mask, .stop_dis);

  function automatic logic [7:0] ref_next(logic [7:0] cur, logic [3:0] cls,
      logic am, logic bm, logic [15:0] r, logic c, logic h);
    logic [7:0] n = cur;
    logic zb = (r[7:0] == 0), zw = (r == 0);
    case (cls)
      1: begin n[0]=c; n[5]=h; n[1]=(am==bm)&&(r[7]!=am); n[3]=r[7]; n[2]=zb; end
      2: begin n[0]=c; n[1]=(am!=bm)&&(r[7]!=am); n[3]=r[7]; n[2]=zb; end
      3: begin n[1]=0; n[3]=r[7]; n[2]=zb; end
      4: begin n[0]=c; n[3]=r[7]; n[2]=zb; n[1]=r[7]^c; end
      5: begin n[0]=c; n[2]=zw; end
      6: n[2]=zw;
      7: begin n=r[7:0]; n[6]=r[6]&cur[6]; end
      default: ;
    endcase
    return n;
  endfunction

  task automatic drive(string tag, logic [3:0] cls, logic am, logic bm,
                       logic [15:0] r, logic c, logic h);
    @(negedge clk);
    op_cls = cls; a_msb = am; b_msb = bm; res = r; alu_c = c; alu_h = h;
    model = ref_next(model, cls, am, bm, r, c, h);
    @(posedge clk); #1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (ccr !== e) begin
        n_bad++;
        $display("FAIL %s: ccr=%02h expected %02h", t, ccr, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: no finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; n_vec++;
    if (ccr !== 8'hD0) begin n_bad++; $display("FAIL R1: ccr=%02h expected d0", ccr); end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; n_vec++;
    if (ccr !== 8'hD0) begin n_bad++; $display("FAIL R1: ccr=%02h expected d0", ccr); end

    drive("R2", 1, 0, 0, 16'h0080, 0, 1);
    drive("R2", 1, 1, 1, 16'h0000, 1, 1);
    drive("R2", 1, 1, 0, 16'h0010, 0, 0);
    drive("R3", 2, 1, 0, 16'h007F, 0, 1);
    drive("R3", 2, 0, 0, 16'h00FF, 1, 0);
    drive("R3", 2, 0, 1, 16'h0000, 1, 0);
    drive("R2", 1, 0, 0, 16'h0008, 0, 1);
    drive("R4", 3, 1, 1, 16'h0000, 1, 0);
    drive("R4", 3, 0, 0, 16'h0081, 0, 0);
    drive("R5", 4, 0, 0, 16'h0080, 0, 0);
    drive("R5", 4, 0, 0, 16'h0000, 1, 0);
    drive("R5", 4, 0, 0, 16'h00C0, 1, 1);
    drive("R6", 5, 1, 1, 16'h0000, 0, 1);
    drive("R6", 5, 0, 0, 16'h8000, 1, 0);
    drive("R7", 6, 1, 0, 16'h0000, 1, 1);
    drive("R7", 6, 0, 0, 16'h0100, 0, 0);
    drive("R8", 0, 1, 1, 16'h0000, 1, 1);
    drive("R8", 15, 0, 1, 16'hFFFF, 0, 1);
    drive("R8", 9, 1, 0, 16'h0000, 1, 0);
    drive("R10", 1, 0, 0, 16'h0000, 1, 1);
    drive("R9", 7, 0, 0, 16'h00AA, 0, 0);
    drive("R9", 7, 0, 0, 16'h0000, 0, 0);
    drive("R9", 7, 0, 0, 16'h00FF, 0, 0);
    drive("R10", 3, 0, 0, 16'h0000, 0, 0);
    drive("R9", 7, 0, 0, 16'h0040, 0, 0);
    @(negedge clk); op_cls = 0;
    repeat (2) @(posedge clk);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule